// File: doc/BRIEF.md
# Address-Coded Bit-Set Output Latch

This block is an eight-bit output port for a 65xx-style bus. A CPU access chooses both the bit and the value to store through the address it uses. Three address lines pick one of the eight output bits. One more address line supplies the value for that bit. A single access therefore sets or clears one output pin, and the CPU does not need to load any of its registers beforehand. The data bus is not used.

The latch-enable input comes from logic outside the block. That logic has already decoded the address and gated it with the high half of phase 2. While the enable is active, the selected bit follows the data line. It keeps following it until the enable falls, and then it holds. An active-low clear empties all eight bits at once.

Inside the block, storage is sampled on a fast system clock. "Follows while enabled" therefore means the selected bit takes the data value on every clock edge during the enable window.

Top module: `addr_latch`

## Requirements
- R1: While `clr_n` is low, `q` is 8'h00. The clear is asynchronous: `q` reaches 0 without waiting for a clock edge.
- R2: The clear takes priority over the enable. With `clr_n` low and `en` high, `q` stays 8'h00 across clock edges.
- R3: At a rising `clk` edge with `en` high and `clr_n` high, bit `q[sel]` takes the value of `din`. `sel` is an unsigned binary index: 0 selects `q[0]` and 7 selects `q[7]`.
- R4: During such a write, every bit other than `q[sel]` keeps its previous value. At most one bit of `q` changes per clock edge.
- R5: At a rising edge with `en` low, all of `q` keeps its value, whatever `sel` and `din` are doing.
- R6: Transparency. While `en` stays high, the selected bit tracks every change of `din` from one edge to the next. The value present at the last edge before `en` falls is the one that is kept.
- R7: Each of the eight bits can be set to 1 and then cleared to 0 on its own, using only `sel` and `din`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System sampling clock |
| clr_n | input | 1 | Asynchronous clear of all bits, active low |
| en | input | 1 | Latch enable, already decoded and gated by phase 2 |
| sel | input | 3 | Index of the bit to write, taken from address lines |
| din | input | 1 | Value for the selected bit, taken from an address line |
| q | output | 8 | Latched output bits |

## Verification
A write presented with `en` high shows up on `q` after exactly one rising edge. The bench changes the inputs on a falling edge and reads `q` on the next falling edge, so every read falls half a period after the edge that produced it. The clear is the one result that does not wait for a clock: the bench lowers `clr_n` partway through a low clock phase and reads `q` 2 ns later, before any rising edge arrives. Hold cases (`en` low) are read after the same one-edge delay, so any unwanted update would already be visible on `q` when it is read.

// File: rtl/addr_latch_pkg.sv
package addr_latch_pkg;
  localparam int DEF_BITS = 8;

  // True when a binary select value addresses bit position idx.
  function automatic logic sel_hits(input int unsigned sel_val, input int unsigned idx);
    return sel_val == idx;
  endfunction
endpackage

// File: rtl/addr_latch_dec.sv
module addr_latch_dec #(
  parameter int NBITS = 8,
  parameter int SEL_W = $clog2(NBITS)
) (
  input  logic             en,
  input  logic [SEL_W-1:0] sel,
  output logic [NBITS-1:0] wr_mask
);
  import addr_latch_pkg::*;

  for (genvar i = 0; i < NBITS; i++) begin : g_hit
    always_comb wr_mask[i] = en & sel_hits(int'(sel), i);
  end
endmodule

// File: rtl/addr_latch_cell.sv
module addr_latch_cell (
  input  logic clk,
  input  logic clr_n,
  input  logic wr,
  input  logic din,
  output logic q
);
  always_ff @(posedge clk or negedge clr_n) begin
    if (!clr_n)  q <= 1'b0;
    else if (wr) q <= din;
  end
endmodule

// File: rtl/addr_latch.sv
module addr_latch #(
  parameter int NBITS = addr_latch_pkg::DEF_BITS,
  parameter int SEL_W = $clog2(NBITS)
) (
  input  logic             clk,
  input  logic             clr_n,
  input  logic             en,
  input  logic [SEL_W-1:0] sel,
  input  logic             din,
  output logic [NBITS-1:0] q
);
  // Named internal event: one-hot write strobe per bit.
  logic [NBITS-1:0] wr_mask;

  addr_latch_dec #(.NBITS(NBITS), .SEL_W(SEL_W)) u_dec (
    .en      (en),
    .sel     (sel),
    .wr_mask (wr_mask)
  );

  for (genvar i = 0; i < NBITS; i++) begin : g_cell
    addr_latch_cell u_cell (
      .clk   (clk),
      .clr_n (clr_n),
      .wr    (wr_mask[i]),
      .din   (din),
      .q     (q[i])
    );
  end
endmodule

// File: rtl/addr_latch_chk.sv
module addr_latch_chk #(
  parameter int NBITS = 8,
  parameter int SEL_W = 3
) (
  input logic             clk,
  input logic             clr_n,
  input logic             en,
  input logic [SEL_W-1:0] sel,
  input logic             din,
  input logic [NBITS-1:0] q,
  input logic [NBITS-1:0] wr_mask
);
  assert_clear_zero_R1: assert property (@(posedge clk)
    !clr_n |-> q == '0);

  assert_clear_beats_en_R2: assert property (@(posedge clk)
    (!clr_n && en) |-> q == '0);

  assert_sel_takes_din_R3: assert property (@(posedge clk) disable iff (!clr_n)
    en |=> q[$past(sel)] == $past(din));

  assert_strobe_onehot_R3: assert property (@(posedge clk) disable iff (!clr_n)
    en |-> $onehot(wr_mask));

  assert_one_bit_moves_R4: assert property (@(posedge clk) disable iff (!clr_n)
    $countones(q ^ $past(q)) <= 1);

  assert_hold_when_idle_R5: assert property (@(posedge clk) disable iff (!clr_n)
    !en |=> $stable(q));

  assert_no_strobe_idle_R5: assert property (@(posedge clk) disable iff (!clr_n)
    !en |-> wr_mask == '0);
endmodule

bind addr_latch addr_latch_chk #(.NBITS(NBITS), .SEL_W(SEL_W)) u_chk (
  .clk     (clk),
  .clr_n   (clr_n),
  .en      (en),
  .sel     (sel),
  .din     (din),
  .q       (q),
  .wr_mask (wr_mask)
);

// File: tb/addr_latch_test.sv
`timescale 1ns/1ps
module addr_latch_test;
  logic       clk = 1'b0;
  logic       clr_n = 1'b0;
  logic       en = 1'b0;
  logic [2:0] sel = '0;
  logic       din = 1'b0;
  logic [7:0] q;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  addr_latch uut (
    .clk   (clk),
    .clr_n (clr_n),
    .en    (en),
    .sel   (sel),
    .din   (din),
    .q     (q)
  );

  // Vector: {en, sel[2:0], din, expected q[7:0]}
  localparam int NV = 16;
  localparam logic [12:0] VEC [NV] = '{
    {1'b1, 3'd3, 1'b1, 8'h08},
    {1'b1, 3'd0, 1'b1, 8'h09},
    {1'b1, 3'd7, 1'b1, 8'h89},
    {1'b0, 3'd5, 1'b1, 8'h89},
    {1'b0, 3'd2, 1'b1, 8'h89},
    {1'b1, 3'd3, 1'b0, 8'h81},
    {1'b1, 3'd7, 1'b0, 8'h01},
    {1'b1, 3'd6, 1'b1, 8'h41},
    {1'b1, 3'd6, 1'b0, 8'h01},
    {1'b1, 3'd6, 1'b1, 8'h41},
    {1'b0, 3'd6, 1'b0, 8'h41},
    {1'b1, 3'd1, 1'b1, 8'h43},
    {1'b1, 3'd2, 1'b1, 8'h47},
    {1'b1, 3'd4, 1'b1, 8'h57},
    {1'b0, 3'd0, 1'b0, 8'h57},
    {1'b1, 3'd0, 1'b0, 8'h56}
  };

  task automatic check(input string req, input logic [7:0] exp);
    total++;
    if (q !== exp) begin
      bad++;
      $display("FAIL %s: q=%h expected=%h", req, q, exp);
    end
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: run did not finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] model;
    // R1: clear held low through several edges with en high (R2)
    en = 1'b1; sel = 3'd2; din = 1'b1;
    repeat (3) @(negedge clk);
    check("R1", 8'h00);
    check("R2", 8'h00);
    en = 1'b0;
    @(negedge clk);
    clr_n = 1'b1;
    @(negedge clk);
    check("R1", 8'h00);

    // Table walk: change on falling edge, read on next falling edge
    for (int i = 0; i < NV; i++) begin
      en  = VEC[i][12];
      sel = VEC[i][11:9];
      din = VEC[i][8];
      @(negedge clk);
      check(VEC[i][12] ? "R3/R4/R6" : "R5", VEC[i][7:0]);
    end
    en = 1'b0;
    @(negedge clk);

    // R1: asynchronous clear mid low phase, read before any rising edge
    #1 clr_n = 1'b0;
    #2 check("R1", 8'h00);
    @(negedge clk);
    clr_n = 1'b1;
    @(negedge clk);

    // R7: every bit set then cleared on its own
    model = 8'h00;
    for (int b = 0; b < 8; b++) begin
      en = 1'b1; sel = 3'(b); din = 1'b1;
      model[b] = 1'b1;
      @(negedge clk);
      check("R7", model);
    end
    for (int b = 0; b < 8; b++) begin
      en = 1'b1; sel = 3'(b); din = 1'b0;
      model[b] = 1'b0;
      @(negedge clk);
      check("R7", model);
    end

    // R5: idle with wildly moving sel/din keeps value
    en = 1'b1; sel = 3'd5; din = 1'b1;
    @(negedge clk);
    en = 1'b0;
    for (int k = 0; k < 8; k++) begin
      sel = 3'(k); din = k[0];
      @(negedge clk);
    end
    check("R5", 8'h20);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule